// File: doc/BRIEF.md
# Compressed Index Sequence Generator

This block turns a bit mask into a stream of scaled indices. A single start pulse loads a mask and a signed stride. For every set bit, the block then emits one element, equal to that bit's position multiplied by the stride. Position 0 is the most significant mask bit, and positions rise toward the least significant bit. Elements come out one per clock, in rising position order, and the final one carries a last flag.

The number of set bits is the length of the generated vector. It is presented on a count output from the cycle after the start is taken and held until the next accepted start. Following masked operations can use it directly as their vector length. A one-cycle done pulse closes each run, including a run with an empty mask. While a run is in progress the block is busy and ignores further start requests.

Top module: `cidx_gen`

## Requirements
- R1: From the cycle after a start is accepted, `count_o` equals the number of set bits in the loaded mask. It holds that value until the next accepted start.
- R2: Each emitted element equals p × stride, truncated to a 32-bit two's-complement value. Here p is the position of its mask bit, where bit 63 of `mask_i` is position 0 and bit 0 is position 63.
- R3: Elements appear on consecutive cycles starting the cycle after the start is accepted, in strictly increasing position order, with no gaps. There is exactly one element per set bit.
- R4: `elem_last_o` is high together with the final element of a run and on no other cycle.
- R5: An all-zero mask produces no elements. `done_o` pulses the cycle after the start, and `count_o` reads 0.
- R6: A `start_i` raised while `busy_o` is high is ignored. The running sequence, its stride and `count_o` are unchanged.
- R7: After reset, `busy_o`, `elem_valid_o`, `elem_last_o` and `done_o` are low and `count_o` is 0.
- R8: `done_o` pulses for one cycle, the cycle after the final element (or after the start for an empty mask). `busy_o` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load request, taken when not busy |
| mask_i | input | 64 | Selection mask, MSB is position 0 |
| stride_i | input | 32 | Signed stride |
| busy_o | output | 1 | Run in progress |
| elem_valid_o | output | 1 | Element output is valid |
| elem_data_o | output | 32 | Scaled index element |
| elem_last_o | output | 1 | Final element of the run |
| done_o | output | 1 | One-cycle end-of-run pulse |
| count_o | output | 7 | Number of set bits, the vector length |

## Verification
The assertions assume that `start_i` is a clean synchronous level. They also assume the mask and stride are meaningful only in the cycle the start is accepted, so they check the block's own sequencing: the last flag never appears without a valid element, a done pulse ends the busy state, and the number of emitted elements matches the count. The stimulus raises start only for one cycle while idle. The one exception is deliberate: it raises start mid-run, with a different mask and stride, to exercise the ignore rule. Strides cover zero, positive, negative and large magnitudes, so that the truncated products stay well defined.

// File: rtl/cidx_pkg.sv
// Package: shared widths for the compressed index generator.
// Assumes the mask width is a power of two no wider than 2**31.
package cidx_pkg;
    localparam int MASK_W = 64;
    localparam int IDX_W  = 32;
    localparam int POS_W  = $clog2(MASK_W);
    localparam int CNT_W  = $clog2(MASK_W + 1);
endpackage

// File: rtl/cidx_lead_find.sv
// Module: finds the set bit with the smallest position (position 0 = MSB).
// Assumes nothing about the input; found_o is low for an all-zero vector.
module cidx_lead_find #(
    parameter int W     = 64,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic             found_o,
    output logic [POS_W-1:0] pos_o,
    output logic [W-1:0]     onehot_o
);
    // Scan from LSB upward so the highest set bit wins last.
    always_comb begin
        found_o  = 1'b0;
        pos_o    = '0;
        onehot_o = '0;
        for (int b = 0; b < W; b++) begin
            if (vec_i[b]) begin
                found_o  = 1'b1;
                pos_o    = POS_W'(W - 1 - b);
                onehot_o = '0;
                onehot_o[b] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cidx_popcnt.sv
// Module: population count of a vector.
// Assumes CNT_W can hold the value W.
module cidx_popcnt #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Sum every bit of the vector.
    always_comb begin
        cnt_o = '0;
        for (int b = 0; b < W; b++) begin
            cnt_o = cnt_o + CNT_W'(vec_i[b]);
        end
    end
endmodule

// File: rtl/cidx_scale.sv
// Module: multiplies an unsigned position by a signed stride.
// Assumes IDX_W > POS_W; the result is truncated to IDX_W bits.
module cidx_scale #(
    parameter int POS_W = 6,
    parameter int IDX_W = 32
) (
    input  logic [POS_W-1:0]        pos_i,
    input  logic signed [IDX_W-1:0] stride_i,
    output logic [IDX_W-1:0]        prod_o
);
    logic signed [IDX_W-1:0] pos_ext;

    // Zero-extend the position and form the wrapped product.
    always_comb begin
        pos_ext = IDX_W'(pos_i);
        prod_o  = pos_ext * stride_i;
    end
endmodule

// File: rtl/cidx_gen.sv
// Module: compressed index generator top. It loads a mask and a stride on
// start, then emits position*stride for each set bit, one per cycle, MSB
// first, followed by a done pulse. Assumes start is sampled synchronously;
// starts while busy are dropped.
module cidx_gen
    import cidx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [MASK_W-1:0]       mask_i,
    input  logic signed [IDX_W-1:0] stride_i,
    output logic                    busy_o,
    output logic                    elem_valid_o,
    output logic [IDX_W-1:0]        elem_data_o,
    output logic                    elem_last_o,
    output logic                    done_o,
    output logic [CNT_W-1:0]        count_o
);
    localparam logic [MASK_W-1:0] ONE = MASK_W'(1);

    logic                    busy_q;
    logic [MASK_W-1:0]       rem_q;
    logic signed [IDX_W-1:0] stride_q;
    logic [CNT_W-1:0]        count_q;
    logic [CNT_W-1:0]        emitted_q;
    logic [CNT_W-1:0]        pop_w;
    logic                    found_w;
    logic [POS_W-1:0]        pos_w;
    logic [MASK_W-1:0]       onehot_w;
    logic                    accept_w;

    cidx_popcnt #(.W(MASK_W), .CNT_W(CNT_W)) u_pop (
        .vec_i (mask_i),
        .cnt_o (pop_w)
    );

    cidx_lead_find #(.W(MASK_W), .POS_W(POS_W)) u_find (
        .vec_i    (rem_q),
        .found_o  (found_w),
        .pos_o    (pos_w),
        .onehot_o (onehot_w)
    );

    cidx_scale #(.POS_W(POS_W), .IDX_W(IDX_W)) u_scale (
        .pos_i    (pos_w),
        .stride_i (stride_q),
        .prod_o   (elem_data_o)
    );

    // Start is only taken when idle.
    assign accept_w = start_i && !busy_q;

    // Run control: load on accept, retire one set bit per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            rem_q    <= '0;
            stride_q <= '0;
            count_q  <= '0;
        end else if (accept_w) begin
            busy_q   <= 1'b1;
            rem_q    <= mask_i;
            stride_q <= stride_i;
            count_q  <= pop_w;
        end else if (busy_q) begin
            if (!found_w) begin
                busy_q <= 1'b0;
            end else begin
                rem_q <= rem_q & ~onehot_w;
            end
        end
    end

    // Tally of elements emitted in the current run, for the count check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emitted_q <= '0;
        end else if (accept_w) begin
            emitted_q <= '0;
        end else if (elem_valid_o) begin
            emitted_q <= emitted_q + CNT_W'(1);
        end
    end

    // Output decode from the run state.
    always_comb begin
        busy_o       = busy_q;
        elem_valid_o = busy_q && found_w;
        elem_last_o  = elem_valid_o && ((rem_q & (rem_q - ONE)) == '0);
        done_o       = busy_q && !found_w;
        count_o      = count_q;
    end

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        elem_last_o |-> elem_valid_o); // R4
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && !elem_last_o) |=> elem_valid_o); // R3
    AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        elem_last_o |=> (done_o && !elem_valid_o)); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R8
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (emitted_q == count_o)); // R1
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(count_o) && $stable(stride_q))); // R6
    AST_BIT_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && !start_i) |=> ($countones(rem_q) == $countones($past(rem_q)) - 1)); // R3
endmodule

// File: tb/cidx_gen_test.sv
`timescale 1ns/1ps
module cidx_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] mask_i = '0;
    logic signed [31:0] stride_i = '0;
    logic        busy_o, elem_valid_o, elem_last_o, done_o;
    logic [31:0] elem_data_o;
    logic [6:0]  count_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cidx_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .stride_i(stride_i), .busy_o(busy_o), .elem_valid_o(elem_valid_o),
        .elem_data_o(elem_data_o), .elem_last_o(elem_last_o),
        .done_o(done_o), .count_o(count_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One run: expected elements computed from position*stride, MSB = position 0.
    task automatic run_case(input logic [63:0] m, input logic signed [31:0] s, input bit poke);
        int exp_n;
        int k;
        exp_n = 0;
        for (int b = 0; b < 64; b++) if (m[b]) exp_n++;
        @(negedge clk);
        start_i = 1'b1; mask_i = m; stride_i = s;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 count", 64'(count_o), 64'(exp_n));
        k = 0;
        for (int p = 0; p < 64; p++) begin
            if (m[63 - p]) begin
                int e;
                e = p * s;
                if (poke && k == 0) begin
                    start_i = 1'b1; mask_i = ~m; stride_i = s + 7;
                end
                chk("R3 valid", 64'(elem_valid_o), 64'd1);
                chk("R2 data", 64'(elem_data_o), 64'(e[31:0]));
                chk("R4 last", 64'(elem_last_o), 64'(k == exp_n - 1));
                chk("R8 no early done", 64'(done_o), 64'd0);
                k++;
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        chk("R8 done", 64'(done_o), 64'd1);
        chk("R5 R3 no extra elem", 64'(elem_valid_o), 64'd0);
        chk("R6 count held", 64'(count_o), 64'(exp_n));
        @(negedge clk);
        chk("R8 idle", 64'(busy_o), 64'd0);
        chk("R8 done one cycle", 64'(done_o), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R3 watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] lfsr;
        repeat (3) @(negedge clk);
        chk("R7 busy", 64'(busy_o), 64'd0);
        chk("R7 valid", 64'(elem_valid_o), 64'd0);
        chk("R7 last", 64'(elem_last_o), 64'd0);
        chk("R7 done", 64'(done_o), 64'd0);
        chk("R7 count", 64'(count_o), 64'd0);
        rst_n = 1'b1;
        run_case({64{1'b1}}, 32'sd1, 1'b0);
        run_case({32{2'b01}}, 32'sd1, 1'b0);
        run_case({32{2'b01}}, 32'sd2, 1'b0);
        run_case({64{1'b1}}, 32'sd5, 1'b0);
        run_case(64'd0, 32'sd9, 1'b0);                 // R5
        run_case(64'h8000_0000_0000_0001, -32'sd3, 1'b0);
        run_case(64'h0F00_00F0_0000_F00F, 32'sd0, 1'b0);
        run_case(64'hFFFF_0000_FFFF_0000, 32'sh4000_0001, 1'b0);
        run_case(64'hA5A5_5A5A_0FF0_1234, 32'sd11, 1'b1); // R6
        run_case(64'd0, 32'sd1, 1'b1);                 // R6 with empty mask
        for (int b = 0; b < 64; b++) run_case(64'd1 << b, 32'sd3, 1'b0);
        lfsr = 64'hACE1_2468_1357_BDF0;
        for (int t = 0; t < 40; t++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            run_case(lfsr, 32'(t * 977 - 20000), (t % 5) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule